// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block decides whether a memory access may proceed. It holds a small bank of programmable protection regions. Each region has a base address, a power-of-two size, an enable bit and two independent permission sets, one for privileged code and one for user code. The address is never translated. The checker only compares it against the regions and then applies the permission set of the region that wins.

Each access presents an address, a kind (data read, data write or instruction fetch) and a privilege flag. One clock later the block returns a registered verdict. The verdict gives allow or fault, whether any region matched and the index of the deciding region. When the verdict is a fault, it also returns the access kind and the faulting address, so that an exception handler can read them. The regions are loaded through a simple register write port. Each write targets one region and selects either that region's base word or its attribute word.

The attribute word uses these bit positions:
- bit 0: enable
- bits 5:1: size as a power of two
- bits 7:6: privileged access code
- bit 8: privileged execute permit
- bits 10:9: user access code
- bit 11: user execute permit

Access codes:
- 00: no access
- 01: read-only
- 10 and 11: read-write

Top module: `region_guard`

## Requirements
- R1: After synchronous reset every region is disabled and every result output is 0. An access made right after reset therefore hits no region.
- R2: A result appears on the clock edge after the access is presented, with res_valid high for exactly that cycle. While res_valid is low, res_allow, res_fault, res_hit, res_region, res_fault_kind and res_fault_addr are all 0.
- R3: An enabled region matches an address when the address agrees with the region base on all bits at or above the region's size exponent. Exponents below 5 are treated as 5, so the minimum region size is 32 bytes. On a miss, res_hit and res_region are 0.
- R4: When several enabled regions match the same address, the one with the highest index decides the result and is reported in res_region.
- R5: An access that matches no enabled region is allowed when privileged and faults when made from user mode.
- R6: The access kind encoding is 00 = read, 01 = write, 10 = instruction fetch, 11 = treated as a read. A read is allowed for access codes 01, 10 and 11. A write is allowed only for codes 10 and 11. Code 00 faults every kind.
- R7: An instruction fetch is allowed only when the access code permits reads and the execute permit bit of the same mode is 1. A fetch from a readable region whose execute permit is 0 faults.
- R8: Privileged accesses use attribute bits 8:6 and user accesses use bits 11:9. Each mode is judged only by its own field, so the same region can grant different rights to the two modes.
- R9: For every result, exactly one of res_allow and res_fault is high. On a fault, res_fault_kind and res_fault_addr carry the kind and address of that access. On an allowed access they are 0.
- R10: A configuration write has effect on accesses presented in the cycles after it. It has no effect on an access presented in the same cycle. Write field 0 selects the base word and field 1 selects the attribute word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Region targeted by the write |
| cfg_field | input | 1 | 0 selects the base word, 1 selects the attribute word |
| cfg_wdata | input | ADDR_W | Write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| acc_priv | input | 1 | 1 for a privileged access |
| res_valid | output | 1 | Verdict present |
| res_allow | output | 1 | Access permitted |
| res_fault | output | 1 | Access denied |
| res_hit | output | 1 | Some enabled region matched |
| res_region | output | IDX_W | Index of the deciding region |
| res_fault_kind | output | 2 | Kind of the faulting access |
| res_fault_addr | output | ADDR_W | Address of the faulting access |

## Verification
Directed cases probe the following:
- Region edges: the last byte inside a region and the first byte outside it, which separates a correct mask width from one that is off by one bit.
- The 32-byte floor: an undersized exponent, which shows whether the floor is applied.
- Nested regions: overlapping regions, which tell highest-index priority apart from lowest-index priority.
- Fetch from readable memory: readable regions with and without the execute permit, which separate the fetch rule from the read rule.
- Split permissions: regions whose privileged and user fields differ, which expose a swapped mode selection.
- Same-cycle write: a configuration write issued in the same cycle as an access, which tests the ordering between the write and the lookup.

Random programming of overlapping regions in a narrow address window, mixed with random accesses near the region bases, covers the combinations of these rules.

// File: rtl/rg_pkg.sv
package rg_pkg;

  // Access kinds presented by the requester
  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_OTHER = 2'b11
  } acc_kind_e;

  // Attribute word of one region, bit 0 is the enable
  typedef struct packed {
    logic       usr_x;
    logic [1:0] usr_ap;
    logic       prv_x;
    logic [1:0] prv_ap;
    logic [4:0] size_log2;
    logic       en;
  } rg_attr_t;

  localparam int ATTR_W = $bits(rg_attr_t);

  // Decide one mode's rights for one access kind
  function automatic logic rights_ok(input logic [1:0] ap, input logic x,
                                     input logic [1:0] kind);
    logic rd, wr;
    rd = (ap != 2'b00);
    wr = ap[1];
    case (kind)
      KIND_WRITE: rights_ok = wr;
      KIND_FETCH: rights_ok = rd & x;
      default:    rights_ok = rd;
    endcase
  endfunction

endpackage

// File: rtl/rg_region_slot.sv
module rg_region_slot
  import rg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 3,
  parameter int SLOT_ID   = 0,
  parameter int MIN_LOG2  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_field,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] probe_addr,
  output rg_attr_t          attr,
  output logic              hit
);

  localparam logic [IDX_W-1:0] MY_ID = IDX_W'(SLOT_ID);

  logic [ADDR_W-1:0] base_q;
  rg_attr_t          attr_q;
  logic [ADDR_W-1:0] mask;
  int unsigned       eff_log2;

  wire sel = cfg_we && (cfg_idx == MY_ID);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      attr_q <= '0;
    end else if (sel) begin
      if (cfg_field) attr_q <= rg_attr_t'(cfg_wdata[ATTR_W-1:0]);
      else           base_q <= cfg_wdata;
    end
  end

  // Size floor then a mask covering the bits above the region size
  always_comb begin
    eff_log2 = (int'(attr_q.size_log2) < MIN_LOG2) ? MIN_LOG2
                                                   : int'(attr_q.size_log2);
    for (int i = 0; i < ADDR_W; i++) begin
      mask[i] = (i >= int'(eff_log2));
    end
  end

  assign hit  = attr_q.en && ((probe_addr & mask) == (base_q & mask));
  assign attr = attr_q;

endmodule

// File: rtl/rg_priority_pick.sv
module rg_priority_pick
  import rg_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = 3
) (
  input  logic     [NUM_REGIONS-1:0] hits,
  input  rg_attr_t [NUM_REGIONS-1:0] attrs,
  output logic                       any_hit,
  output logic     [IDX_W-1:0]       win_idx,
  output rg_attr_t                   win_attr
);

  // Ascending scan: a later match overrides, so the top index wins
  always_comb begin
    any_hit  = 1'b0;
    win_idx  = '0;
    win_attr = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (hits[r]) begin
        any_hit  = 1'b1;
        win_idx  = IDX_W'(r);
        win_attr = attrs[r];
      end
    end
  end

endmodule

// File: rtl/rg_access_judge.sv
module rg_access_judge
  import rg_pkg::*;
(
  input  logic       any_hit,
  input  rg_attr_t   win_attr,
  input  logic [1:0] kind,
  input  logic       priv,
  output logic       allow
);

  logic [1:0] ap;
  logic       x;

  always_comb begin
    ap = priv ? win_attr.prv_ap : win_attr.usr_ap;
    x  = priv ? win_attr.prv_x  : win_attr.usr_x;
    if (any_hit) allow = rights_ok(ap, x, kind);
    else         allow = priv;
  end

endmodule

// File: rtl/region_guard.sv
module region_guard
  import rg_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int MIN_LOG2    = 5,
  localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_field,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic              acc_priv,
  output logic              res_valid,
  output logic              res_allow,
  output logic              res_fault,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_region,
  output logic [1:0]        res_fault_kind,
  output logic [ADDR_W-1:0] res_fault_addr
);

  logic     [NUM_REGIONS-1:0] hits;
  rg_attr_t [NUM_REGIONS-1:0] attrs;
  logic                       any_hit;
  logic     [IDX_W-1:0]       win_idx;
  rg_attr_t                   win_attr;
  logic                       allow;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_slot
    rg_region_slot #(
      .ADDR_W   (ADDR_W),
      .IDX_W    (IDX_W),
      .SLOT_ID  (g),
      .MIN_LOG2 (MIN_LOG2)
    ) u_slot (
      .clk        (clk),
      .rst        (rst),
      .cfg_we     (cfg_we),
      .cfg_idx    (cfg_idx),
      .cfg_field  (cfg_field),
      .cfg_wdata  (cfg_wdata),
      .probe_addr (acc_addr),
      .attr       (attrs[g]),
      .hit        (hits[g])
    );
  end

  rg_priority_pick #(
    .NUM_REGIONS (NUM_REGIONS),
    .IDX_W       (IDX_W)
  ) u_pick (
    .hits     (hits),
    .attrs    (attrs),
    .any_hit  (any_hit),
    .win_idx  (win_idx),
    .win_attr (win_attr)
  );

  rg_access_judge u_judge (
    .any_hit  (any_hit),
    .win_attr (win_attr),
    .kind     (acc_kind),
    .priv     (acc_priv),
    .allow    (allow)
  );

  // Registered verdict; all fields zero when no access was presented
  always_ff @(posedge clk) begin
    if (rst || !acc_valid) begin
      res_valid      <= 1'b0;
      res_allow      <= 1'b0;
      res_fault      <= 1'b0;
      res_hit        <= 1'b0;
      res_region     <= '0;
      res_fault_kind <= '0;
      res_fault_addr <= '0;
    end else begin
      res_valid      <= 1'b1;
      res_allow      <= allow;
      res_fault      <= !allow;
      res_hit        <= any_hit;
      res_region     <= win_idx;
      res_fault_kind <= allow ? 2'b00 : acc_kind;
      res_fault_addr <= allow ? '0 : acc_addr;
    end
  end

endmodule

// File: rtl/rg_checker.sv
module rg_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        acc_kind,
  input logic              acc_priv,
  input logic              res_valid,
  input logic              res_allow,
  input logic              res_fault,
  input logic              res_hit,
  input logic [IDX_W-1:0]  res_region,
  input logic [1:0]        res_fault_kind,
  input logic [ADDR_W-1:0] res_fault_addr
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) acc_valid |=> res_valid) else $error("valid"); // R2
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst) !acc_valid |=> !res_valid) else $error("idle"); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !res_valid |-> !res_allow && !res_fault && !res_hit && res_region == '0 && res_fault_addr == '0) else $error("quiet"); // R2
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst) res_valid |-> $onehot({res_allow, res_fault})) else $error("verdict"); // R9
  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (rst) acc_valid |=> res_fault |-> (res_fault_addr == $past(acc_addr) && res_fault_kind == $past(acc_kind))) else $error("faddr"); // R9
  AST_MISS_RULE: assert property (@(posedge clk) disable iff (rst) acc_valid |=> (!res_hit |-> res_allow == $past(acc_priv))) else $error("miss"); // R5
  AST_MISS_INDEX: assert property (@(posedge clk) disable iff (rst) !res_hit |-> res_region == '0) else $error("index"); // R3

endmodule

bind region_guard rg_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rg_checker (
  .clk            (clk),
  .rst            (rst),
  .acc_valid      (acc_valid),
  .acc_addr       (acc_addr),
  .acc_kind       (acc_kind),
  .acc_priv       (acc_priv),
  .res_valid      (res_valid),
  .res_allow      (res_allow),
  .res_fault      (res_fault),
  .res_hit        (res_hit),
  .res_region     (res_region),
  .res_fault_kind (res_fault_kind),
  .res_fault_addr (res_fault_addr)
);

// File: tb/region_guard_bench.sv
`timescale 1ns/1ps
module region_guard_bench;

  localparam int NR = 8;
  localparam int AW = 32;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic          cfg_field = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0]    acc_kind = 2'b00;
  logic          acc_priv = 1'b0;
  logic          res_valid, res_allow, res_fault, res_hit;
  logic [IW-1:0] res_region;
  logic [1:0]    res_fault_kind;
  logic [AW-1:0] res_fault_addr;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [AW-1:0] m_base [NR];
  logic [11:0]   m_attr [NR];

  always #5 clk = ~clk;

  region_guard #(.NUM_REGIONS(NR), .ADDR_W(AW)) u_region_guard (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_priv(acc_priv),
    .res_valid(res_valid), .res_allow(res_allow), .res_fault(res_fault),
    .res_hit(res_hit), .res_region(res_region),
    .res_fault_kind(res_fault_kind), .res_fault_addr(res_fault_addr)
  );

  function automatic logic [31:0] mk_attr(input bit en, input int szl,
      input logic [1:0] pap, input bit px, input logic [1:0] uap, input bit ux);
    return {20'd0, ux, uap, px, pap, 5'(szl), en};
  endfunction

  // Reference decision computed from the requirement text
  function automatic void model(input logic [AW-1:0] a, input logic [1:0] k,
      input bit p, output bit e_allow, output bit e_hit, output logic [IW-1:0] e_idx);
    logic [1:0] ap;
    bit x;
    int eff;
    logic [AW-1:0] msk;
    e_hit = 0; e_idx = '0; ap = 2'b00; x = 0;
    for (int r = 0; r < NR; r++) begin
      eff = (int'(m_attr[r][5:1]) < 5) ? 5 : int'(m_attr[r][5:1]);
      msk = {AW{1'b1}} << eff;
      if (m_attr[r][0] && ((a & msk) == (m_base[r] & msk))) begin
        e_hit = 1; e_idx = IW'(r);
        ap = p ? m_attr[r][7:6] : m_attr[r][10:9];
        x  = p ? m_attr[r][8]   : m_attr[r][11];
      end
    end
    if (!e_hit)            e_allow = p;
    else if (k == 2'b01)   e_allow = ap[1];
    else if (k == 2'b10)   e_allow = (ap != 2'b00) && x;
    else                   e_allow = (ap != 2'b00);
  endfunction

  task automatic compare(input string tag, input logic [AW-1:0] a,
      input logic [1:0] k, input bit ea, input bit eh, input logic [IW-1:0] ei);
    logic [1:0]    ek;
    logic [AW-1:0] ead;
    ek  = ea ? 2'b00 : k;
    ead = ea ? '0 : a;
    n_vec++;
    if (res_valid !== 1'b1 || res_allow !== ea || res_fault !== !ea ||
        res_hit !== eh || res_region !== ei || res_fault_kind !== ek ||
        res_fault_addr !== ead) begin
      n_bad++;
      $display("FAIL %s addr=%h kind=%0d: got v=%b a=%b f=%b h=%b r=%0d fk=%0d fa=%h exp v=1 a=%b f=%b h=%b r=%0d fk=%0d fa=%h",
        tag, a, k, res_valid, res_allow, res_fault, res_hit, res_region,
        res_fault_kind, res_fault_addr, ea, !ea, eh, ei, ek, ead);
    end
  endtask

  // Drive at a falling edge, check at the next falling edge
  task automatic access(input string tag, input logic [AW-1:0] a,
      input logic [1:0] k, input bit p);
    bit ea, eh;
    logic [IW-1:0] ei;
    model(a, k, p, ea, eh, ei);
    acc_valid = 1; acc_addr = a; acc_kind = k; acc_priv = p;
    @(negedge clk);
    acc_valid = 0;
    compare(tag, a, k, ea, eh, ei);
  endtask

  task automatic cfg(input int idx, input bit field, input logic [AW-1:0] d);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_field = field; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (field) m_attr[idx] = d[11:0]; else m_base[idx] = d;
  endtask

  task automatic clear_all();
    for (int r = 0; r < NR; r++) cfg(r, 1, 32'd0);
  endtask

  task automatic check_idle(input string tag);
    n_vec++;
    if (res_valid !== 0 || res_allow !== 0 || res_fault !== 0 || res_hit !== 0 ||
        res_region !== '0 || res_fault_kind !== '0 || res_fault_addr !== '0) begin
      n_bad++;
      $display("FAIL %s idle outputs: got v=%b a=%b f=%b h=%b r=%0d exp all 0",
        tag, res_valid, res_allow, res_fault, res_hit, res_region);
    end
  endtask

  initial begin
    bit ea, eh;
    logic [IW-1:0] ei;
    logic [AW-1:0] a;
    void'($urandom(32'd4242));
    for (int r = 0; r < NR; r++) begin m_base[r] = '0; m_attr[r] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 / R2: quiet after reset, empty region bank
    check_idle("R1");
    access("R1", 32'h0000_0100, 2'b00, 0);
    access("R1", 32'h0000_0100, 2'b01, 1);
    @(negedge clk);
    check_idle("R2");

    // R3: exact edges of a 256-byte region and the 32-byte floor
    cfg(2, 0, 32'h0000_1000);
    cfg(2, 1, mk_attr(1, 8, 2'b10, 1, 2'b10, 1));
    access("R3", 32'h0000_10FF, 2'b01, 0);
    access("R3", 32'h0000_1100, 2'b00, 0);
    access("R3", 32'h0000_0FFF, 2'b00, 0);
    cfg(4, 0, 32'h0000_2000);
    cfg(4, 1, mk_attr(1, 2, 2'b01, 0, 2'b01, 0));
    access("R3", 32'h0000_201F, 2'b00, 0);
    access("R3", 32'h0000_2020, 2'b00, 0);

    // R4: nested regions, top index decides
    cfg(1, 0, 32'h0000_0000);
    cfg(1, 1, mk_attr(1, 16, 2'b10, 1, 2'b00, 0));
    cfg(5, 0, 32'h0000_1000);
    cfg(5, 1, mk_attr(1, 6, 2'b10, 0, 2'b10, 0));
    access("R4", 32'h0000_1010, 2'b01, 0);
    access("R4", 32'h0000_1080, 2'b00, 0);

    // R5: miss outside all regions
    access("R5", 32'h0010_0000, 2'b00, 0);
    access("R5", 32'h0010_0000, 2'b10, 1);

    // R6 / R7 / R8: access codes, execute permit, per-mode fields
    clear_all();
    cfg(3, 0, 32'h0000_4000);
    cfg(3, 1, mk_attr(1, 10, 2'b10, 1, 2'b01, 0));
    access("R6", 32'h0000_4004, 2'b01, 0);
    access("R6", 32'h0000_4004, 2'b11, 0);
    access("R8", 32'h0000_4004, 2'b01, 1);
    access("R7", 32'h0000_4008, 2'b10, 0);
    access("R7", 32'h0000_4008, 2'b10, 1);
    cfg(3, 1, mk_attr(1, 10, 2'b00, 0, 2'b11, 1));
    access("R8", 32'h0000_4010, 2'b00, 1);
    access("R7", 32'h0000_4010, 2'b10, 0);
    access("R9", 32'h0000_4010, 2'b10, 1);

    // R10: write in the same cycle as an access uses the old setting
    cfg(6, 0, 32'h0000_8000);
    model(32'h0000_8040, 2'b01, 0, ea, eh, ei);
    cfg_we = 1; cfg_idx = 3'd6; cfg_field = 1;
    cfg_wdata = mk_attr(1, 8, 2'b10, 0, 2'b10, 0);
    acc_valid = 1; acc_addr = 32'h0000_8040; acc_kind = 2'b01; acc_priv = 0;
    @(negedge clk);
    cfg_we = 0; acc_valid = 0;
    compare("R10", 32'h0000_8040, 2'b01, ea, eh, ei);
    m_attr[6] = 12'(mk_attr(1, 8, 2'b10, 0, 2'b10, 0));
    access("R10", 32'h0000_8040, 2'b01, 0);

    // Random mix over a narrow window so regions overlap
    for (int t = 0; t < 40; t++) begin
      for (int c = 0; c < 3; c++) begin
        int r, szl;
        r = int'($urandom_range(NR - 1));
        szl = int'($urandom_range(12, 3));
        cfg(r, 0, ($urandom & 32'h0000_3FFF) & ({AW{1'b1}} << szl));
        cfg(r, 1, mk_attr(bit'($urandom_range(1)), szl, 2'($urandom), bit'($urandom_range(1)),
                          2'($urandom), bit'($urandom_range(1))));
      end
      for (int v = 0; v < 60; v++) begin
        int r;
        r = int'($urandom_range(NR - 1));
        a = (v % 4 == 0) ? ($urandom & 32'h0000_7FFF)
                         : m_base[r] + ($urandom & 32'h0000_0FFF);
        access("R6", a, 2'($urandom), bit'($urandom_range(1)));
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule